// File: doc/BRIEF.md
# Linear Image Sensor Scan Controller

This block runs on a fast system clock and drives the two timing inputs of a linear photodiode array: a start pulse and a sensor clock. A half-period divider sets the sensor clock rate. Each scan gives the array exactly N+1 sensor clocks, where N is the pixel count. The block then holds the clock low for the charge-transfer wait. It can stretch the start-to-start interval to lengthen the integration time, up to a fixed ceiling.

For every pixel it gives an external converter a one-cycle sample strobe and the pixel index. The strobe comes at the end of each sensor clock period, so that the analog output has settled by then. Each scan carries three status outputs: a data-valid flag, a tag naming the integration window being read out, and a clamp error flag. The pixels read during a scan hold light gathered since the previous start pulse. The first scan after reset only flushes the array, and its data is marked not valid.

Each scan takes its configuration when it starts: the divider value and the requested integration time. The block works out the allowed interval limits in system clock cycles and clamps the request to them. A new scan starts either on a start pulse or, in continuous mode, on its own as soon as the previous interval has run out.

Top module: `sdrv_top`

## Requirements
- R1: While reset is high, and in the first cycles after it is released, every output is low and the tag is 0.
- R2: The sensor start output rises together with the frame-start pulse while the sensor clock is low. It stays high for one sensor period of 2H system cycles, where H is the latched divider value. It falls while the sensor clock is low, so it spans exactly one rising clock edge.
- R3: Within a scan, the sensor clock is low for H cycles and then high for H cycles, giving exactly N+1 rising edges. After that it stays low until the next scan. A divider value of 0 is treated as 1.
- R4: The sample strobe is one cycle wide and comes in the last low cycle before each of rising edges 2 to N+1. The pixel index output carries 0 to N-1 in that order.
- R5: The frame-start pulse comes in the first cycle of the start output. The frame-end pulse comes together with the strobe for the last pixel.
- R6: The interval from one start rise to the next, in system cycles, is the request plus 18×2H. This value is clamped below at (N+1)×2H plus the charge-transfer wait and above at the maximum interval.
- R7: The clamp error output is high for the whole of a scan whose request was clamped, and low otherwise.
- R8: A start pulse that arrives while the current interval is still running is ignored. In continuous mode, the next scan starts as soon as the interval has run out.
- R9: The first scan after reset reports data-valid 0. The tag of scan s (counted from 0 after reset) is s-1 modulo 256, so the first scan carries tag 255.
- R10: The data-valid output is 0 for a scan if the start-to-start interval before it was longer than the maximum interval.
- R11: Changing the divider or the request during a scan does not affect that scan. The new values take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one scan |
| cont_i | input | 1 | Continuous mode: start scans back to back |
| div_i | input | DIV_W | Half sensor period in system cycles |
| int_i | input | INT_W | Requested integration time in system cycles |
| sen_si_o | output | 1 | Start pulse to the array |
| sen_clk_o | output | 1 | Sensor clock to the array |
| px_stb_o | output | 1 | Converter sample strobe |
| px_idx_o | output | clog2(NPIX) | Index of the pixel being sampled |
| frm_start_o | output | 1 | First cycle of a scan |
| frm_end_o | output | 1 | Strobe of the last pixel |
| data_ok_o | output | 1 | The data read in this scan is valid |
| frm_tag_o | output | 8 | Integration window being read out |
| clamp_err_o | output | 1 | This scan's request was clamped |

## Verification
A scan starts one cycle after the edge at which a start pulse is seen or an interval runs out. The start output, the frame-start pulse and all three status outputs change one cycle after that edge. Clock edges and strobes follow at fixed offsets of H and 2H cycles from there. The bench model updates at each rising edge and derives its expected outputs from its state before that update, which reproduces this one-register delay. The outputs are compared at the falling edge, once the registers have settled. Start-to-start gaps are counted in system cycles between observed start rises and compared with values worked out from the clamp formula.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;
    localparam int CYC_W = 32;
    localparam int TAG_W = 8;

    typedef logic [CYC_W-1:0] cyc_t;
    typedef logic [TAG_W-1:0] tag_t;

    // configuration captured at each scan start
    typedef struct packed {
        cyc_t period;   // start-to-start interval, system cycles
        cyc_t half;     // half sensor period, system cycles
        logic clamped;  // request was outside the legal window
    } frame_cfg_t;

    // per-scan tags
    typedef struct packed {
        logic ok;
        tag_t tag;
        logic err;
    } scan_stat_t;

    function automatic cyc_t cyc_max(cyc_t a, cyc_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic cyc_t cyc_min(cyc_t a, cyc_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/sdrv_limit.sv
module sdrv_limit
    import sdrv_pkg::*;
#(
    parameter int NPIX       = 1280,
    parameter int SETUP_CLKS = 18,
    parameter int TQT_CYC    = 2500,
    parameter int MAX_CYC    = 12_500_000,
    parameter int DIV_W      = 14,
    parameter int INT_W      = 24
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [INT_W-1:0] int_i,
    output frame_cfg_t       cfg_o
);
    cyc_t half, per, req, lo, hi;

    always_comb begin
        half = (div_i == '0) ? cyc_t'(1) : cyc_t'(div_i);
        per  = half << 1;
        req  = cyc_t'(int_i) + cyc_t'(SETUP_CLKS) * per;
        lo   = cyc_t'(NPIX + 1) * per + cyc_t'(TQT_CYC);
        hi   = cyc_min(req, cyc_t'(MAX_CYC));
        cfg_o.period  = cyc_max(hi, lo);
        cfg_o.half    = half;
        cfg_o.clamped = (req > cyc_t'(MAX_CYC)) || (req < lo);
    end
endmodule

// File: rtl/sdrv_timer.sv
module sdrv_timer
    import sdrv_pkg::*;
#(
    parameter int MAX_CYC = 12_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       cont_i,
    input  frame_cfg_t cfg_i,
    output logic       go_o,
    output cyc_t       half_o,
    output scan_stat_t stat_o
);
    cyc_t       fc, period_q, half_q;
    logic       first_q;
    tag_t       scan_q;
    scan_stat_t stat_q;
    logic       done;

    assign done   = fc >= (period_q - cyc_t'(1));
    assign go_o   = done && (start_i || cont_i);
    assign half_o = half_q;
    assign stat_o = stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fc       <= cyc_t'(MAX_CYC);   // counts as a long idle gap
            period_q <= cyc_t'(1);
            half_q   <= cyc_t'(1);
            first_q  <= 1'b1;
            scan_q   <= '0;
            stat_q   <= '0;
        end else if (go_o) begin
            fc          <= '0;
            period_q    <= cfg_i.period;
            half_q      <= cfg_i.half;
            first_q     <= 1'b0;
            scan_q      <= scan_q + tag_t'(1);
            stat_q.ok   <= !first_q && (fc < cyc_t'(MAX_CYC));
            stat_q.tag  <= scan_q - tag_t'(1);
            stat_q.err  <= cfg_i.clamped;
        end else if (fc != '1) begin
            fc <= fc + cyc_t'(1);
        end
    end
endmodule

// File: rtl/sdrv_scan.sv
module sdrv_scan
    import sdrv_pkg::*;
#(
    parameter int NPIX = 1280,
    localparam int KW = $clog2(NPIX + 2),
    localparam int IW = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  cyc_t          half_i,
    output logic          si_o,
    output logic          sclk_o,
    output logic          stb_o,
    output logic [IW-1:0] idx_o,
    output logic          fstart_o,
    output logic          fend_o
);
    cyc_t          ph;
    logic [KW-1:0] k;
    logic          act, stb_n;

    assign act   = k <= KW'(NPIX);
    assign stb_n = act && (k != '0) && (ph == half_i - cyc_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= '0;
            k        <= KW'(NPIX + 1);
            si_o     <= 1'b0;
            sclk_o   <= 1'b0;
            stb_o    <= 1'b0;
            idx_o    <= '0;
            fstart_o <= 1'b0;
            fend_o   <= 1'b0;
        end else begin
            si_o     <= act && (k == '0);
            sclk_o   <= act && (ph >= half_i);
            stb_o    <= stb_n;
            idx_o    <= IW'(k - KW'(1));
            fstart_o <= act && (k == '0) && (ph == '0);
            fend_o   <= stb_n && (k == KW'(NPIX));
            if (go_i) begin
                ph <= '0;
                k  <= '0;
            end else if (act) begin
                if (ph == (half_i << 1) - cyc_t'(1)) begin
                    ph <= '0;
                    k  <= k + KW'(1);
                end else begin
                    ph <= ph + cyc_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sdrv_top.sv
module sdrv_top
    import sdrv_pkg::*;
#(
    parameter int NPIX       = 1280,
    parameter int SETUP_CLKS = 18,
    parameter int TQT_CYC    = 2500,
    parameter int MAX_CYC    = 12_500_000,
    parameter int DIV_W      = 14,
    parameter int INT_W      = 24,
    localparam int IW = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [INT_W-1:0] int_i,
    output logic             sen_si_o,
    output logic             sen_clk_o,
    output logic             px_stb_o,
    output logic [IW-1:0]    px_idx_o,
    output logic             frm_start_o,
    output logic             frm_end_o,
    output logic             data_ok_o,
    output logic [TAG_W-1:0] frm_tag_o,
    output logic             clamp_err_o
);
    frame_cfg_t cfg;
    logic       go;
    cyc_t       half;
    scan_stat_t stat, stat_q;

    sdrv_limit #(
        .NPIX(NPIX), .SETUP_CLKS(SETUP_CLKS), .TQT_CYC(TQT_CYC),
        .MAX_CYC(MAX_CYC), .DIV_W(DIV_W), .INT_W(INT_W)
    ) limit_i (
        .div_i(div_i), .int_i(int_i), .cfg_o(cfg)
    );

    sdrv_timer #(.MAX_CYC(MAX_CYC)) timer_i (
        .clk(clk), .rst(rst), .start_i(start_i), .cont_i(cont_i),
        .cfg_i(cfg), .go_o(go), .half_o(half), .stat_o(stat)
    );

    sdrv_scan #(.NPIX(NPIX)) scan_i (
        .clk(clk), .rst(rst), .go_i(go), .half_i(half),
        .si_o(sen_si_o), .sclk_o(sen_clk_o), .stb_o(px_stb_o),
        .idx_o(px_idx_o), .fstart_o(frm_start_o), .fend_o(frm_end_o)
    );

    // align the status with the registered start output
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat;
    end

    assign data_ok_o   = stat_q.ok;
    assign frm_tag_o   = stat_q.tag;
    assign clamp_err_o = stat_q.err;
endmodule

// File: rtl/sdrv_chk.sv
module sdrv_chk (
    input logic clk,
    input logic rst,
    input logic sen_si_o,
    input logic sen_clk_o,
    input logic px_stb_o,
    input logic frm_start_o,
    input logic frm_end_o
);
    assert_si_rise_clk_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sen_si_o) |-> !sen_clk_o);

    assert_si_fall_clk_low_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(sen_si_o) |-> !sen_clk_o);

    assert_stb_before_edge_R4: assert property (@(posedge clk) disable iff (rst)
        px_stb_o |=> $rose(sen_clk_o));

    assert_stb_single_R4: assert property (@(posedge clk) disable iff (rst)
        px_stb_o |=> !px_stb_o);

    assert_fstart_with_si_R5: assert property (@(posedge clk) disable iff (rst)
        frm_start_o |-> $rose(sen_si_o));

    assert_fend_with_stb_R5: assert property (@(posedge clk) disable iff (rst)
        frm_end_o |-> px_stb_o);
endmodule

bind sdrv_top sdrv_chk chk_i (
    .clk(clk), .rst(rst), .sen_si_o(sen_si_o), .sen_clk_o(sen_clk_o),
    .px_stb_o(px_stb_o), .frm_start_o(frm_start_o), .frm_end_o(frm_end_o)
);

// File: tb/sdrv_top_tb.sv
module sdrv_top_tb_top;
    localparam int N     = 24;
    localparam int SETUP = 18;
    localparam int TQT   = 10;
    localparam int MAXC  = 2000;
    localparam int IW    = $clog2(N);

    logic clk = 1'b0;
    logic rst, start, cont;
    logic [7:0]  div;
    logic [15:0] intr;
    logic si, sclk, stb, fs, fe, ok, err;
    logic [IW-1:0] idx;
    logic [7:0] tag;

    always #4 clk = ~clk;

    sdrv_top #(.NPIX(N), .SETUP_CLKS(SETUP), .TQT_CYC(TQT), .MAX_CYC(MAXC),
               .DIV_W(8), .INT_W(16)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .cont_i(cont), .div_i(div),
        .int_i(intr), .sen_si_o(si), .sen_clk_o(sclk), .px_stb_o(stb),
        .px_idx_o(idx), .frm_start_o(fs), .frm_end_o(fe), .data_ok_o(ok),
        .frm_tag_o(tag), .clamp_err_o(err));

    int vectors = 0, fails = 0;
    int cyc = 0, last_rise = 0, last_gap = 0, rise_cnt = 0;
    logic prev_si = 1'b0;

    // behavioural reference: one frame-cycle count since the last start
    longint mfc, mP, mH;
    bit mfirst, mok, merr;
    int msc, mtag;
    bit e_si, e_clk, e_stb, e_fs, e_fe, e_ok, e_err;
    int e_idx, e_tag;

    always @(posedge clk) begin
        longint t, kk, pp, hl, preq, pmin, pe;
        if (rst) begin
            {e_si, e_clk, e_stb, e_fs, e_fe, e_ok, e_err} = '0;
            e_idx = 0; e_tag = 0;
            mfc = MAXC; mP = 1; mH = 1; mfirst = 1; msc = 0;
            mok = 0; merr = 0; mtag = 0;
        end else begin
            t  = 2 * mH;
            kk = mfc / t;
            pp = mfc % t;
            e_si  = (kk == 0) && (mfc < (N + 1) * t);
            e_clk = (mfc < (N + 1) * t) && (pp >= mH);
            e_stb = (mfc < (N + 1) * t) && kk >= 1 && (pp == mH - 1);
            e_idx = int'(kk) - 1;
            e_fs  = (mfc == 0);
            e_fe  = e_stb && (kk == N);
            e_ok = mok; e_tag = mtag; e_err = merr;
            if (mfc >= mP - 1 && (start || cont)) begin
                hl   = (div == 0) ? 1 : longint'(div);
                preq = longint'(intr) + SETUP * 2 * hl;
                pmin = (N + 1) * 2 * hl + TQT;
                pe   = (preq > MAXC) ? MAXC : preq;
                if (pe < pmin) pe = pmin;
                merr = (preq > MAXC) || (preq < pmin);
                mok  = !mfirst && (mfc < MAXC);
                mtag = (msc - 1) & 255;
                msc  = msc + 1;
                mfirst = 0; mP = pe; mH = hl; mfc = 0;
            end else begin
                mfc = mfc + 1;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        vectors++;
        if (!cond) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(si == e_si, "R2 start", si, e_si);
            chk(sclk == e_clk, "R3 clock", sclk, e_clk);
            chk(stb == e_stb, "R4 strobe", stb, e_stb);
            if (e_stb) chk(int'(idx) == e_idx, "R4 index", idx, e_idx);
            chk(fs == e_fs, "R5 frame start", fs, e_fs);
            chk(fe == e_fe, "R5 frame end", fe, e_fe);
            chk(ok == e_ok, "R9 data valid", ok, e_ok);
            chk(int'(tag) == e_tag, "R9 tag", tag, e_tag);
            chk(err == e_err, "R7 clamp flag", err, e_err);
        end
        if (si && !prev_si) begin
            last_gap = cyc - last_rise;
            last_rise = cyc;
            rise_cnt++;
        end
        prev_si = si;
    end

    task automatic next_rise();
        int n = rise_cnt;
        wait (rise_cnt == n + 1);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        #1_200_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1; start = 0; cont = 0; div = 8'd2; intr = 16'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({si, sclk, stb, fs, fe, ok, err} == 7'd0, "R1 outputs", {si, sclk, stb, fs, fe, ok, err}, 0);
        chk(tag == 8'd0, "R1 tag", tag, 0);
        @(negedge clk) rst = 0;
        repeat (2) @(negedge clk);
        chk({si, sclk, stb} == 3'd0, "R1 after release", {si, sclk, stb}, 0);

        // first scan: flush, request below minimum (T=4, min 110)
        pulse_start();
        next_rise();
        chk(ok == 1'b0, "R9 flush scan", ok, 0);
        chk(tag == 8'd255, "R9 first tag", tag, 255);
        chk(err == 1'b1, "R7 low clamp", err, 1);
        repeat (40) @(negedge clk);
        pulse_start();                      // R8: ignored mid-scan
        repeat (200) @(negedge clk);
        pulse_start();
        next_rise();
        chk(ok == 1'b1, "R9 second scan valid", ok, 1);
        chk(tag == 8'd0, "R9 second tag", tag, 0);

        // continuous mode, T=6: 200+108=308
        repeat (150) @(negedge clk);
        div = 8'd3; intr = 16'd200; cont = 1;
        next_rise();
        next_rise();
        chk(last_gap == 308, "R6 in-range gap", last_gap, 308);
        chk(err == 1'b0, "R7 no clamp", err, 0);
        // R11: change mid-scan; this gap keeps the old value
        @(negedge clk) div = 8'd1;
        pulse_start();                      // R8: ignored while running
        next_rise();
        chk(last_gap == 308, "R11 latched config", last_gap, 308);
        @(negedge clk) intr = 16'd5000;
        next_rise();
        chk(last_gap == 236, "R6 new divider", last_gap, 236);
        chk(err == 1'b1, "R7 high clamp", err, 1);
        @(negedge clk) begin div = 8'd0; intr = 16'd0; end
        next_rise();
        chk(last_gap == 2000, "R6 ceiling", last_gap, 2000);
        next_rise();
        chk(last_gap == 60, "R3 divider zero as one", last_gap, 60);

        // R10: idle gap longer than the ceiling
        @(negedge clk) cont = 0;
        repeat (2100) @(negedge clk);
        pulse_start();
        next_rise();
        chk(ok == 1'b0, "R10 stale data", ok, 0);
        repeat (100) @(negedge clk);
        pulse_start();
        next_rise();
        chk(ok == 1'b1, "R10 fresh data", ok, 1);
        repeat (80) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule